// File: doc/BRIEF.md
# Logarithm-Domain Approximate Divider

This block returns an approximate unsigned quotient of two 16-bit operands. It does not use long division. It takes the base-2 logarithm of each operand, subtracts the two logarithms and raises two to the difference.

Each operand is split into an integer exponent, found by locating its leading one, and a mantissa. In the default build the mantissa is centred on one by a square-root-of-two comparison. The fractional logarithm is then a straight-line term plus a small correction table, which is indexed by the upper bits of the mantissa offset. The difference of the two logarithms is split into an integer part and a fraction. A table of powers of two, indexed by the fraction, supplies the result mantissa, and the integer part sets a barrel shift. Because all the arithmetic is in the log domain, the relative error is roughly the same at every magnitude.

An alternative build normalizes the mantissa to [1, 2) and reads the fractional logarithm straight from a table. All tables are computed at elaboration. The unit is fully pipelined and accepts one operation on every clock.

Top module: `log_divider`

## Requirements
- R1: The result of an operation appears exactly three clock edges after the edge that samples `start` high, with `validOut` high for that one cycle. Operations may be issued on consecutive cycles. `validOut` is never high without a matching `start`, and operand values presented while `start` is low produce no output.
- R2: When both operands are nonzero, the 24-bit `quotient` is unsigned fixed point with its low 8 bits fractional. It differs from 256·dividend/divisor by no more than 3 % of that value plus 2 LSB.
- R3: A zero divisor returns `divZero` high together with `validOut`, and `quotient` equal to 0xFFFFFF. This holds even when the dividend is also zero.
- R4: A zero dividend with a nonzero divisor returns `quotient` equal to 0 with `divZero` low.
- R5: The result never wraps. A result beyond the 24-bit range is clamped to 0xFFFFFF, and the largest ratio (65535 / 1) returns a value within the R2 bound.
- R6: When dividend = 2^a and divisor = 2^b, `quotient` equals floor(256·2^(a−b)) exactly. That is 2^(a−b+8) when a−b ≥ −8, and 0 otherwise.
- R7: While reset is asserted, `validOut`, `divZero` and `quotient` are all zero.
- R8: With `CENTER` = 0 (direct-table build), the unit meets R1, R2, R3, R4 and R6 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept the operands on this edge |
| dividend | input | W (16) | Unsigned numerator |
| divisor | input | W (16) | Unsigned denominator |
| quotient | output | W+FRAC (24) | Unsigned quotient, FRAC (8) fractional bits |
| validOut | output | 1 | Quotient and flag are valid this cycle |
| divZero | output | 1 | The divisor of the returned operation was zero |

## Verification
The assertions check several properties on every cycle:
- the three-cycle link between `start` and `validOut`, in both directions;
- the pairing of `divZero` with an all-ones quotient;
- the zero-dividend short cut;
- in the centred build, that each fractional logarithm stays within half an octave plus a small margin.

Numerical accuracy can only be shown by the bench scenarios. These compare each result with real-number division across random operands of mixed magnitude, all pairs of powers of two, the largest and smallest ratios, and the zero cases. The same scenarios also cover the direct-table build and confirm that idle operand changes produce nothing.

// File: rtl/ld_pkg.sv
`timescale 1ns/1ps
package ld_pkg;
  // Pipeline depth from the start edge to the result: operand, log, output registers.
  localparam int LATENCY = 3;

  // Load strobes from control to datapath, one per register stage.
  typedef struct packed {
    logic capOps;
    logic capLog;
    logic capOut;
  } ldStrobe_t;
endpackage

// File: rtl/ld_log_unit.sv
`timescale 1ns/1ps
// Approximate base-2 logarithm of an unsigned operand, signed fixed point with FRAC fraction bits.
module ld_log_unit #(
  parameter int W          = 16,
  parameter int FRAC       = 8,
  parameter int CENTER     = 1,
  parameter int CORR_BITS  = 5,
  parameter int PLAIN_BITS = 6
) (
  input  logic [W-1:0]                     operand,
  output logic signed [$clog2(W)+FRAC+1:0] logOut,
  output logic signed [FRAC+1:0]           fracOut
);
  localparam int KW   = $clog2(W) + 1;
  localparam int FW   = FRAC + 2;
  localparam int LOGW = KW + FRAC + 1;

  typedef logic signed [FW-1:0] corrTab_t  [2**CORR_BITS];
  typedef logic signed [FW-1:0] plainTab_t [2**PLAIN_BITS];

  // Correction = log2(1+d) - d/ln2, taken at the centre of each bin of d in [-0.5, 0.5).
  function automatic corrTab_t mkCorr();
    corrTab_t t;
    for (int i = 0; i < 2**CORR_BITS; i++) begin
      real dc, cv;
      dc = (real'(i) + 0.5) / real'(2**CORR_BITS) - 0.5;
      cv = ($ln(1.0 + dc) - dc) / $ln(2.0);
      t[i] = FW'(longint'(cv * real'(2**FRAC)));
    end
    return t;
  endfunction

  // Direct fractional log for a mantissa in [1, 2), bin centres.
  function automatic plainTab_t mkPlain();
    plainTab_t t;
    for (int i = 0; i < 2**PLAIN_BITS; i++) begin
      real mv;
      mv = 1.0 + (real'(i) + 0.5) / real'(2**PLAIN_BITS);
      t[i] = FW'(longint'($ln(mv) / $ln(2.0) * real'(2**FRAC)));
    end
    return t;
  endfunction

  logic [KW-1:0]         msbIdx;
  logic [KW-1:0]         kVal;
  logic [W-1:0]          norm;
  logic                  nonZero;
  logic signed [FW-1:0]  fracVal;

  // Leading-one detector: highest set bit wins.
  always_comb begin
    msbIdx = '0;
    for (int i = 0; i < W; i++)
      if (operand[i]) msbIdx = KW'(i);
  end

  assign norm    = operand << (KW'(W - 1) - msbIdx);
  assign nonZero = norm[W-1];

  generate
    if (CENTER != 0) begin : g_center
      localparam int DW     = W + 2;
      localparam int CB     = 12;
      localparam int PW     = DW + CB + 2;
      localparam int LIN_SH = W + CB - FRAC;
      localparam logic [W-1:0]           SQRT2_N = W'(longint'($sqrt(2.0) * real'(2**(W-1))));
      localparam logic signed [PW-1:0]   LN_CS   = PW'(longint'(real'(2**CB) / $ln(2.0)));
      localparam logic signed [DW-1:0]   HALF    = DW'(2**(W-1));
      localparam logic signed [DW-1:0]   ONE     = DW'(2**W);
      localparam corrTab_t               CORR    = mkCorr();

      logic                   above;
      logic signed [DW-1:0]   dVal;
      logic signed [PW-1:0]   dExt;
      logic [CORR_BITS-1:0]   idx;
      logic signed [FW-1:0]   linVal;

      always_comb begin
        above   = norm >= SQRT2_N;
        // d in W fraction bits: mantissa halved when it passes sqrt(2).
        dVal    = above ? ($signed({2'b00, norm}) - ONE)
                        : ($signed({1'b0, norm, 1'b0}) - ONE);
        dExt    = {{(PW-DW){dVal[DW-1]}}, dVal};
        linVal  = FW'((dExt * LN_CS) >>> LIN_SH);
        idx     = CORR_BITS'((dVal + HALF) >>> (W - CORR_BITS));
        fracVal = linVal + CORR[idx];
      end
      assign kVal = msbIdx + KW'(above);
    end else begin : g_plain
      localparam plainTab_t PLAIN = mkPlain();
      logic [PLAIN_BITS-1:0] idx;
      assign idx     = PLAIN_BITS'(norm >> (W - 1 - PLAIN_BITS));
      assign fracVal = PLAIN[idx];
      assign kVal    = msbIdx;
    end
  endgenerate

  always_comb begin
    logOut  = $signed({1'b0, kVal, {FRAC{1'b0}}})
            + $signed({{(LOGW-FW){fracVal[FW-1]}}, fracVal});
    fracOut = fracVal;
    if (!nonZero) begin
      logOut  = '0;
      fracOut = '0;
    end
  end
endmodule

// File: rtl/ld_ctrl.sv
`timescale 1ns/1ps
// Valid pipeline that issues one load strobe per datapath stage.
module ld_ctrl
  import ld_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output ldStrobe_t strobe,
  output logic      validOut
);
  logic [LATENCY-1:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[LATENCY-2:0], start};
  end

  assign strobe.capOps = start;
  assign strobe.capLog = vPipe[0];
  assign strobe.capOut = vPipe[1];
  assign validOut      = vPipe[LATENCY-1];
endmodule

// File: rtl/ld_datapath.sv
`timescale 1ns/1ps
// Operand registers, log difference, antilog with barrel shift, saturation.
module ld_datapath
  import ld_pkg::*;
#(
  parameter int W          = 16,
  parameter int FRAC       = 8,
  parameter int CENTER     = 1,
  parameter int CORR_BITS  = 5,
  parameter int PLAIN_BITS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ldStrobe_t        strobe,
  input  logic [W-1:0]     dividend,
  input  logic [W-1:0]     divisor,
  output logic [W+FRAC-1:0] quotient,
  output logic             divZero
);
  localparam int KW   = $clog2(W) + 1;
  localparam int LOGW = KW + FRAC + 1;
  localparam int FW   = FRAC + 2;
  localparam int DFW  = LOGW + 1;
  localparam int QW   = W + FRAC;
  localparam int OFF  = W + 1;
  localparam int RSH  = OFF + W - 1 - FRAC;
  localparam int WW   = 3 * W + 2;
  localparam int ALN  = 2**FRAC;
  localparam logic signed [DFW-1:0] OFF_S = DFW'(OFF);

  typedef logic [W-1:0] alTab_t [ALN];

  // Mantissa 2^(i/ALN) with W-1 fraction bits.
  function automatic alTab_t mkAnti();
    alTab_t t;
    for (int i = 0; i < ALN; i++)
      t[i] = W'(longint'((2.0 ** (real'(i) / real'(ALN))) * real'(2**(W-1))));
    return t;
  endfunction
  localparam alTab_t ANTI = mkAnti();

  // Stage A: operands.
  logic [W-1:0] yA, xA;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      yA <= '0;
      xA <= '0;
    end else if (strobe.capOps) begin
      yA <= dividend;
      xA <= divisor;
    end
  end

  // Logs of both operands: index 0 dividend, index 1 divisor.
  logic [W-1:0]           opV   [2];
  logic signed [LOGW-1:0] logV  [2];
  logic signed [FW-1:0]   fracV [2];
  assign opV[0] = yA;
  assign opV[1] = xA;

  for (genvar g = 0; g < 2; g++) begin : g_log
    ld_log_unit #(
      .W(W), .FRAC(FRAC), .CENTER(CENTER),
      .CORR_BITS(CORR_BITS), .PLAIN_BITS(PLAIN_BITS)
    ) u_log (
      .operand (opV[g]),
      .logOut  (logV[g]),
      .fracOut (fracV[g])
    );
  end

  // Stage B: log difference and zero flags.
  logic signed [DFW-1:0] diffB;
  logic                  dzB, yzB;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diffB <= '0;
      dzB   <= 1'b0;
      yzB   <= 1'b0;
    end else if (strobe.capLog) begin
      diffB <= {logV[0][LOGW-1], logV[0]} - {logV[1][LOGW-1], logV[1]};
      dzB   <= (xA == '0);
      yzB   <= (yA == '0);
    end
  end

  // Antilog: table for the fraction, barrel shift for the integer part.
  logic signed [DFW-1:0] ipVal, shVal;
  logic [FRAC-1:0]       fpVal;
  logic [WW-1:0]         wide, qFull;
  logic [QW-1:0]         qNext;
  always_comb begin
    ipVal = diffB >>> FRAC;
    fpVal = diffB[FRAC-1:0];
    shVal = ipVal + OFF_S;
    wide  = WW'(ANTI[fpVal]) << shVal;
    qFull = wide >> RSH;
    if (dzB)                      qNext = '1;
    else if (yzB || shVal < 0)    qNext = '0;
    else if (|qFull[WW-1:QW])     qNext = '1;
    else                          qNext = qFull[QW-1:0];
  end

  // Stage C: result.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotient <= '0;
      divZero  <= 1'b0;
    end else if (strobe.capOut) begin
      quotient <= qNext;
      divZero  <= dzB;
    end
  end

  // Centred build: each fractional log stays within half an octave plus a small margin.
  if (CENTER != 0) begin : g_chk
    localparam int LIM = 2**(FRAC-1) + 2**(FRAC-5);
    for (genvar g = 0; g < 2; g++) begin : g_op
      p_frac_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
        strobe.capLog |-> (fracV[g] <= FW'(LIM)) && (fracV[g] >= -FW'(LIM)));
    end
  end
endmodule

// File: rtl/log_divider.sv
`timescale 1ns/1ps
// Top: log-domain approximate divider, three-stage pipeline.
module log_divider
  import ld_pkg::*;
#(
  parameter int W          = 16,
  parameter int FRAC       = 8,
  parameter int CENTER     = 1,
  parameter int CORR_BITS  = 5,
  parameter int PLAIN_BITS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [W-1:0]      dividend,
  input  logic [W-1:0]      divisor,
  output logic [W+FRAC-1:0] quotient,
  output logic              validOut,
  output logic              divZero
);
  ldStrobe_t strobe;

  ld_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .strobe   (strobe),
    .validOut (validOut)
  );

  ld_datapath #(
    .W(W), .FRAC(FRAC), .CENTER(CENTER),
    .CORR_BITS(CORR_BITS), .PLAIN_BITS(PLAIN_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dividend (dividend),
    .divisor  (divisor),
    .quotient (quotient),
    .divZero  (divZero)
  );

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    start |-> ##3 validOut);

  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> $past(start, 3));

  p_dz_allones_r3: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && divZero) |-> (&quotient));

  p_dz_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && divisor == '0) |-> ##3 (validOut && divZero));

  p_zero_dividend_r4: assert property (@(posedge clk) disable iff (!rstN)
    (start && dividend == '0 && divisor != '0) |-> ##3 (quotient == '0 && !divZero));
endmodule

// File: tb/log_divider_tb.sv
`timescale 1ns/1ps
module log_divider_tb;
  localparam int  W   = 16;
  localparam int  QW  = 24;
  localparam real TOL = 0.03;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  dividend = '0;
  logic [W-1:0]  divisor = '0;
  logic [QW-1:0] qC, qP;
  logic          vC, vP, zC, zP;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  bit finished = 0;

  typedef struct { int due; int xv; int yv; } exp_t;
  exp_t expQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  log_divider #(.CENTER(1)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .quotient(qC), .validOut(vC), .divZero(zC));

  log_divider #(.CENTER(0)) u_plain (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .quotient(qP), .validOut(vP), .divZero(zP));

  function automatic bit isPow2(int v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  task automatic checkResult(string who, string pre, logic [QW-1:0] q, logic z, int xv, int yv);
    string tag;
    bit ok;
    real e;
    e = 0.0;
    if (xv == 0) begin
      tag = "R3";
      ok  = z && (q == '1);
      e   = 16777215.0;
    end else if (yv == 0) begin
      tag = "R4";
      ok  = !z && (q == '0);
    end else begin
      e = real'(yv) * 256.0 / real'(xv);
      if (isPow2(xv) && isPow2(yv)) begin
        tag = "R6";
        ok  = !z && (longint'(q) == longint'($floor(e)));
        e   = $floor(e);
      end else begin
        tag = (yv == 65535 && xv == 1) ? "R5" : "R2";
        ok  = !z && ((real'(q) - e) <= e * TOL + 2.0) && ((e - real'(q)) <= e * TOL + 2.0);
      end
    end
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s%s %s: y=%0d x=%0d actual q=%0d dz=%0b expected q=%0.2f", pre, tag, who,
               yv, xv, q, z, e);
    end
  endtask

  // Reference schedule compared on every clock.
  always @(negedge clk) begin
    bit   due;
    exp_t e;
    if (rstN && !finished) begin
      due = (expQ.size() > 0) && (expQ[0].due == edgeCnt);
      checks++;
      if (vC !== due) begin
        errors++;
        $display("FAIL R1 centred: validOut actual %b expected %b at edge %0d", vC, due, edgeCnt);
      end
      checks++;
      if (vP !== due) begin
        errors++;
        $display("FAIL R8/R1 direct: validOut actual %b expected %b at edge %0d", vP, due, edgeCnt);
      end
      if (due) begin
        e = expQ.pop_front();
        checkResult("centred", "", qC, zC, e.xv, e.yv);
        checkResult("direct", "R8/", qP, zP, e.xv, e.yv);
      end
    end
  end

  task automatic issue(int xv, int yv);
    @(negedge clk);
    start    = 1'b1;
    divisor  = W'(xv);
    dividend = W'(yv);
    expQ.push_back('{edgeCnt + 3, xv, yv});
  endtask

  // Idle cycles with changing operands: must not produce results (R1).
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start    = 1'b0;
      divisor  = W'($urandom);
      dividend = W'($urandom);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog: actual run still active, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R7: reset state.
    repeat (3) @(negedge clk);
    checks++;
    if (vC || zC || qC != '0 || vP || zP || qP != '0) begin
      errors++;
      $display("FAIL R7: actual v=%b dz=%b q=%0d expected 0 0 0", vC, zC, qC);
    end
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // R1 single operation and latency.
    issue(7, 1000);
    idle(5);

    // R3 / R4 zero operands.
    issue(0, 1234);
    issue(0, 0);
    issue(99, 0);
    issue(1, 0);
    idle(4);

    // R5 extreme ratios.
    issue(1, 65535);
    issue(65535, 1);
    issue(65535, 65535);
    issue(3, 65535);
    idle(3);

    // R6 all pairs of powers of two, back to back.
    for (int a = 0; a < W; a++)
      for (int b = 0; b < W; b++)
        issue(1 << b, 1 << a);
    idle(4);

    // R2 random operands of mixed magnitude, back to back.
    for (int i = 0; i < 300; i++) begin
      int xv, yv;
      yv = int'($urandom_range(1, 65535)) >> $urandom_range(0, 15);
      xv = int'($urandom_range(1, 65535)) >> $urandom_range(0, 15);
      if (yv == 0) yv = 1;
      if (xv == 0) xv = 1;
      issue(xv, yv);
    end

    // R1 random gaps between operations.
    for (int i = 0; i < 60; i++) begin
      int xv, yv;
      yv = int'($urandom_range(0, 65535));
      xv = int'($urandom_range(0, 65535));
      issue(xv, yv);
      idle(int'($urandom_range(0, 3)));
    end

    idle(8);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R1 drain: actual %0d results outstanding, expected 0", expQ.size());
    end
    summary();
    $finish;
  end
endmodule